// File: doc/BRIEF.md
# Dword-to-Halfword Host Bridge

This block lets a 32-bit host reach the memories of a processor core through that core's narrow, slow memory-access port. Each host dword becomes two 16-bit word transactions on the core side, low half first. Every core word takes several core clocks, so the bridge takes in host writes into a small write buffer and answers them at once. Host reads get a retry answer until both halves have come back. The host repeats the read to collect the data.

Two host-visible registers steer the core address. A pointer register holds a word address and a data/program memory select. A mode register chooses indirect or direct addressing. In indirect mode every completed core word advances the pointer, so the bridge never reads ahead: it reads exactly the two words of the dword the host asked for. In direct mode the host address itself supplies the memory select and the dword index, and the pointer is left alone.

Top module: `dword_word_bridge`

## Requirements
- R1: In every cycle with `h_valid` high, exactly one of `h_ack` and `h_retry` is high. With `h_valid` low, both are low.
- R2: A dword goes out as two core words: bits 15:0 to word address A first, then bits 31:16 to A+1. `c_req`, `c_we`, `c_mem`, `c_addr` and `c_wdata` hold steady until the cycle in which `c_done` is seen.
- R3: A data write is acknowledged while the write buffer (default 8 dwords, in addition to the dword being transferred) has room. When the buffer is full, the write is answered with retry and is dropped.
- R4: A data read is answered with retry while its two core words are fetched. The next data read after both words complete is acknowledged, with `h_rdata` = {high word, low word}.
- R5: In indirect mode a dword read advances the pointer by exactly 2. No word beyond the requested dword is read.
- R6: In indirect mode successive data writes go to consecutive word addresses starting at the pointer. The pointer advances by one per completed core word.
- R7: Register space is `h_addr[15]`=0, with `h_addr[0]` selecting pointer (0) or mode (1). The pointer register holds the word address in bits 13:0 and the memory select in bit 16 (1 = program memory). That select drives `c_mem` for indirect transfers.
- R8: The mode register resets to 0x0001 (bit 0 = 1, indirect). With bit 0 = 0 (direct), a data-window access uses `h_addr[14]` as the memory select and word address `h_addr[12:0]`×2, and the pointer does not change.
- R9: A register access is answered with retry while the write buffer is non-empty or a core transfer is in progress.
- R10: After reset the pointer reads 0x00000000 and `c_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host request present this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 16 | Bit 15 selects data window (1) or registers (0) |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Request completed this cycle |
| h_retry | output | 1 | Request refused; host must repeat it |
| h_rdata | output | 32 | Read data, valid with `h_ack` on a read |
| c_req | output | 1 | Core word transfer requested |
| c_we | output | 1 | Core transfer is a write |
| c_mem | output | 1 | 0 = data memory, 1 = program memory |
| c_addr | output | 14 | Core word address |
| c_wdata | output | 16 | Core write word |
| c_rdata | input | 16 | Core read word, valid with `c_done` |
| c_done | input | 1 | One-cycle pulse ending the current word |

## Verification
The hardest state to reach from the ports is a full write buffer. The engine pops the first dword one cycle after it arrives, so the host must issue writes on consecutive cycles, faster than two slow core words can drain. The bench sends ten writes back-to-back against a core model with five-cycle latency. It expects the tenth to retry, then confirms from the core transaction stream and the pointer readback that the nine accepted dwords landed in order and the refused one left no trace. The no-read-ahead rule is shown by reading the pointer back after an indirect read and finding it advanced by exactly two.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    localparam int HOST_W = 32;
    localparam int CORE_W = 16;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LO,
        ENG_HI
    } eng_state_e;
endpackage

// File: rtl/dwb_wbuf.sv
module dwb_wbuf #(
    parameter int W     = 47,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } wb_state_t;

    wb_state_t st_d, st_q;
    logic [W-1:0] slot_q [DEPTH];

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign dout  = slot_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        if (pop)  st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[st_q.wr] <= din;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/dwb_regs.sv
module dwb_regs #(
    parameter int CA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ptr,
    input  logic [CA_W-1:0] ptr_wval,
    input  logic            mem_wval,
    input  logic            wr_mode,
    input  logic            ind_wval,
    input  logic            inc,
    output logic [CA_W-1:0] ptr,
    output logic            mem,
    output logic            ind
);
    typedef struct packed {
        logic [CA_W-1:0] ptr;
        logic            mem;
        logic            ind;
    } rg_state_t;

    rg_state_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_ptr) begin
            rg_d.ptr = ptr_wval;
            rg_d.mem = mem_wval;
        end else if (inc) begin
            rg_d.ptr = rg_q.ptr + CA_W'(1);
        end
        if (wr_mode) rg_d.ind = ind_wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.ptr <= '0;
            rg_q.mem <= 1'b0;
            rg_q.ind <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ptr = rg_q.ptr;
    assign mem = rg_q.mem;
    assign ind = rg_q.ind;

    // R5
    ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ptr && !inc) |=> $stable(rg_q.ptr));
endmodule

// File: rtl/dwb_engine.sv
module dwb_engine
    import dwb_pkg::*;
#(
    parameter int CA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              ld_we,
    input  logic              ld_mem,
    input  logic              ld_ind,
    input  logic [CA_W-1:0]   ld_addr,
    input  logic [HOST_W-1:0] ld_data,
    input  logic [CORE_W-1:0] c_rdata,
    input  logic              c_done,
    output logic              busy,
    output logic              c_req,
    output logic              c_we,
    output logic              c_mem,
    output logic [CA_W-1:0]   c_addr,
    output logic [CORE_W-1:0] c_wdata,
    output logic              ptr_inc,
    output logic              rd_valid,
    output logic [HOST_W-1:0] rd_data
);
    typedef struct packed {
        eng_state_e        st;
        logic              we;
        logic              mem;
        logic              ind;
        logic [CA_W-1:0]   addr;
        logic [HOST_W-1:0] data;
    } eng_t;

    eng_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        case (en_q.st)
            ENG_IDLE: if (ld) begin
                en_d.st   = ENG_LO;
                en_d.we   = ld_we;
                en_d.mem  = ld_mem;
                en_d.ind  = ld_ind;
                en_d.addr = ld_addr;
                en_d.data = ld_data;
            end
            ENG_LO: if (c_done) begin
                if (!en_q.we) en_d.data[CORE_W-1:0] = c_rdata;
                en_d.addr = en_q.addr + CA_W'(1);
                en_d.st   = ENG_HI;
            end
            ENG_HI: if (c_done) begin
                if (!en_q.we) en_d.data[HOST_W-1:CORE_W] = c_rdata;
                en_d.st = ENG_IDLE;
            end
            default: en_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '{st: ENG_IDLE, default: '0};
        else        en_q <= en_d;
    end

    assign busy     = (en_q.st != ENG_IDLE);
    assign c_req    = busy;
    assign c_we     = en_q.we;
    assign c_mem    = en_q.mem;
    assign c_addr   = en_q.addr;
    assign c_wdata  = (en_q.st == ENG_HI) ? en_q.data[HOST_W-1:CORE_W] : en_q.data[CORE_W-1:0];
    assign ptr_inc  = busy && c_done && en_q.ind;
    assign rd_valid = (en_q.st == ENG_HI) && c_done && !en_q.we;
    assign rd_data  = {c_rdata, en_q.data[CORE_W-1:0]};

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_done) |=> (c_req && $stable(c_addr) && $stable(c_we)
                                && $stable(c_mem) && $stable(c_wdata)));
    // R2
    lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_done && en_q.st == ENG_LO) |=> (c_req && c_addr == $past(c_addr) + CA_W'(1)));
    // R9
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> !busy);
endmodule

// File: rtl/dword_word_bridge.sv
module dword_word_bridge
    import dwb_pkg::*;
#(
    parameter int CA_W     = 14,
    parameter int HA_W     = 16,
    parameter int WB_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    input  logic              h_write,
    input  logic [HA_W-1:0]   h_addr,
    input  logic [31:0]       h_wdata,
    output logic              h_ack,
    output logic              h_retry,
    output logic [31:0]       h_rdata,
    output logic              c_req,
    output logic              c_we,
    output logic              c_mem,
    output logic [CA_W-1:0]   c_addr,
    output logic [15:0]       c_wdata,
    input  logic [15:0]       c_rdata,
    input  logic              c_done
);
    localparam int DI_W  = CA_W - 1;
    localparam int ENT_W = 2 + DI_W + HOST_W;
    localparam int MSEL  = HA_W - 2;
    localparam int WIN   = HA_W - 1;

    typedef struct packed {
        logic              ind;
        logic              mem;
        logic [DI_W-1:0]   dw;
        logic [HOST_W-1:0] data;
    } wb_ent_t;

    typedef struct packed {
        logic              rd_ready;
        logic [HOST_W-1:0] rd_buf;
    } top_t;

    top_t tp_d, tp_q;

    logic              eng_busy, fb_empty, fb_full, push, pop, start_rd, ld;
    logic              wr_ptr, wr_mode, ptr_inc, rd_valid, busy;
    logic              rg_mem, rg_ind, ld_mem, ld_ind, ld_we;
    logic [CA_W-1:0]   rg_ptr, ld_addr;
    logic [HOST_W-1:0] rd_data, ld_data, ptr_word;
    wb_ent_t           ent_in, ent_out;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^h_addr[MSEL-1:DI_W];

    assign busy   = eng_busy || !fb_empty;
    assign ent_in = '{ind: rg_ind, mem: h_addr[MSEL], dw: h_addr[DI_W-1:0], data: h_wdata};

    always_comb begin
        ptr_word            = '0;
        ptr_word[CA_W-1:0]  = rg_ptr;
        ptr_word[16]        = rg_mem;
    end

    always_comb begin
        tp_d     = tp_q;
        h_ack    = 1'b0;
        h_retry  = 1'b0;
        h_rdata  = '0;
        push     = 1'b0;
        start_rd = 1'b0;
        wr_ptr   = 1'b0;
        wr_mode  = 1'b0;
        if (h_valid) begin
            if (h_addr[WIN]) begin
                if (h_write) begin
                    if (fb_full) h_retry = 1'b1;
                    else begin
                        h_ack = 1'b1;
                        push  = 1'b1;
                    end
                end else if (tp_q.rd_ready) begin
                    h_ack         = 1'b1;
                    h_rdata       = tp_q.rd_buf;
                    tp_d.rd_ready = 1'b0;
                end else begin
                    h_retry  = 1'b1;
                    start_rd = !busy;
                end
            end else if (busy) begin
                h_retry = 1'b1;
            end else begin
                h_ack = 1'b1;
                if (h_write) begin
                    wr_mode = h_addr[0];
                    wr_ptr  = !h_addr[0];
                end else begin
                    h_rdata = h_addr[0] ? {31'b0, rg_ind} : ptr_word;
                end
            end
        end
        if (rd_valid) begin
            tp_d.rd_ready = 1'b1;
            tp_d.rd_buf   = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign pop = !eng_busy && !fb_empty;
    assign ld  = start_rd || pop;

    always_comb begin
        if (start_rd) begin
            ld_we   = 1'b0;
            ld_ind  = rg_ind;
            ld_mem  = rg_ind ? rg_mem : h_addr[MSEL];
            ld_addr = rg_ind ? rg_ptr : {h_addr[DI_W-1:0], 1'b0};
            ld_data = '0;
        end else begin
            ld_we   = 1'b1;
            ld_ind  = ent_out.ind;
            ld_mem  = ent_out.ind ? rg_mem : ent_out.mem;
            ld_addr = ent_out.ind ? rg_ptr : {ent_out.dw, 1'b0};
            ld_data = ent_out.data;
        end
    end

    dwb_wbuf #(.W(ENT_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(push), .din(ent_in),
        .pop(pop), .dout(ent_out), .empty(fb_empty), .full(fb_full)
    );

    dwb_regs #(.CA_W(CA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ptr(wr_ptr), .ptr_wval(h_wdata[CA_W-1:0]), .mem_wval(h_wdata[16]),
        .wr_mode(wr_mode), .ind_wval(h_wdata[0]), .inc(ptr_inc),
        .ptr(rg_ptr), .mem(rg_mem), .ind(rg_ind)
    );

    dwb_engine #(.CA_W(CA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_we(ld_we), .ld_mem(ld_mem),
        .ld_ind(ld_ind), .ld_addr(ld_addr), .ld_data(ld_data),
        .c_rdata(c_rdata), .c_done(c_done), .busy(eng_busy),
        .c_req(c_req), .c_we(c_we), .c_mem(c_mem), .c_addr(c_addr),
        .c_wdata(c_wdata), .ptr_inc(ptr_inc), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // R1
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({h_ack, h_retry}) && ((h_ack || h_retry) == h_valid));
    // R4
    rd_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tp_q.rd_ready) |-> $past(c_done));
    // R9
    reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && !h_addr[WIN] && h_ack) |-> !c_req);
endmodule

// File: tb/tb_dword_word_bridge.sv
`timescale 1ns/1ps
module tb_dword_word_bridge;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_valid = 1'b0, h_write = 1'b0;
    logic [15:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ack, h_retry;
    logic [31:0] h_rdata;
    logic        c_req, c_we, c_mem;
    logic [13:0] c_addr;
    logic [15:0] c_wdata;
    logic [15:0] c_rdata = '0;
    logic        c_done = 1'b0;

    always #2.5 clk = ~clk;

    dword_word_bridge dut (
        .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_write(h_write),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_ack(h_ack), .h_retry(h_retry),
        .h_rdata(h_rdata), .c_req(c_req), .c_we(c_we), .c_mem(c_mem),
        .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_done(c_done)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        we;
        logic        mem;
        logic [13:0] addr;
        logic [15:0] data;
    } xact_t;
    xact_t sbq[$];

    task automatic push_exp(input bit we, input bit mem, input logic [13:0] a, input logic [15:0] d);
        xact_t x;
        x.we = we; x.mem = mem; x.addr = a; x.data = d;
        sbq.push_back(x);
    endtask

    // core model and scoreboard monitor, run on the falling edge
    logic [15:0] dm [256];
    logic [15:0] pm [256];
    int lat_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            c_done  <= 1'b0;
            lat_cnt <= 0;
        end else begin
            c_done <= 1'b0;
            if (c_req && !c_done) begin
                if (lat_cnt == LAT - 1) begin
                    xact_t e;
                    c_done  <= 1'b1;
                    lat_cnt <= 0;
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R2", "unexpected core word", {2'b0, c_addr, c_wdata}, '0);
                    end else begin
                        e = sbq.pop_front();
                        chk(c_we == e.we && c_mem == e.mem && c_addr == e.addr &&
                            (!e.we || c_wdata == e.data), "R2", "core word",
                            {c_we, c_mem, c_addr, c_wdata}, {e.we, e.mem, e.addr, e.data});
                    end
                    if (c_we) begin
                        if (c_mem) pm[c_addr[7:0]] <= c_wdata;
                        else       dm[c_addr[7:0]] <= c_wdata;
                    end else begin
                        c_rdata <= c_mem ? pm[c_addr[7:0]] : dm[c_addr[7:0]];
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic hacc(input bit wr, input logic [15:0] a, input logic [31:0] d,
                        output bit ack, output bit rty, output logic [31:0] rd);
        @(negedge clk);
        h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = d;
        #1;
        ack = h_ack; rty = h_retry; rd = h_rdata;
        chk(ack ^ rty, "R1", "one answer per request", {30'b0, ack, rty}, 32'h1);
        @(posedge clk);
        #1;
        h_valid = 1'b0;
    endtask

    task automatic reg_acc(input bit wr, input logic [15:0] a, input logic [31:0] d,
                           output logic [31:0] rd);
        bit ack, rty;
        int n = 0;
        do begin
            hacc(wr, a, d, ack, rty, rd);
            n++;
        end while (!ack && n < 2000);
    endtask

    task automatic data_rd(input logic [15:0] a, output logic [31:0] rd,
                           output int tries, output bit first_rty);
        bit ack, rty;
        tries = 0;
        first_rty = 1'b0;
        do begin
            hacc(1'b0, a, '0, ack, rty, rd);
            if (tries == 0) first_rty = rty;
            tries++;
        end while (!ack && tries < 2000);
    endtask

    task automatic drain();
        int n = 0;
        while (sbq.size() != 0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    logic [13:0] exp_ptr = '0;
    logic        exp_mem = 1'b0;

    task automatic ind_wr(input logic [31:0] d, output bit ack);
        bit rty;
        logic [31:0] rd;
        hacc(1'b1, 16'h8000, d, ack, rty, rd);
        if (ack) begin
            push_exp(1'b1, exp_mem, exp_ptr, d[15:0]);
            push_exp(1'b1, exp_mem, exp_ptr + 14'd1, d[31:16]);
            exp_ptr = exp_ptr + 14'd2;
        end
    endtask

    task automatic set_ptr(input bit mem, input logic [13:0] p);
        logic [31:0] rd;
        reg_acc(1'b1, 16'h0000, {15'b0, mem, 2'b0, p}, rd);
        exp_ptr = p;
        exp_mem = mem;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit ack, rty, first_rty;
        int tries;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R1: idle after reset
        #1;
        chk(!c_req, "R10", "no core request after reset", {31'b0, c_req}, 0);
        chk(!h_ack && !h_retry, "R1", "no answer while idle", {30'b0, h_ack, h_retry}, 0);
        reg_acc(1'b0, 16'h0001, '0, rd);
        chk(rd == 32'h1, "R8", "mode register reset value", rd, 32'h1);
        reg_acc(1'b0, 16'h0000, '0, rd);
        chk(rd == 32'h0, "R10", "pointer reset value", rd, 32'h0);

        // R6 / R2: indirect writes to data memory
        set_ptr(1'b0, 14'h010);
        ind_wr(32'hA1B2C3D4, ack);
        chk(ack, "R3", "write accepted with empty buffer", {31'b0, ack}, 1);
        hacc(1'b0, 16'h0000, '0, ack, rty, rd);
        chk(rty, "R9", "register access retried while busy", {31'b0, rty}, 1);
        ind_wr(32'h11223344, ack);
        drain();
        reg_acc(1'b0, 16'h0000, '0, rd);
        chk(rd == 32'h14, "R6", "pointer after two indirect writes", rd, 32'h14);

        // R4 / R5: indirect read, retried then collected, no read ahead
        set_ptr(1'b0, 14'h010);
        push_exp(1'b0, 1'b0, 14'h010, '0);
        push_exp(1'b0, 1'b0, 14'h011, '0);
        data_rd(16'h8000, rd, tries, first_rty);
        chk(first_rty, "R4", "first read attempt retried", {31'b0, first_rty}, 1);
        chk(tries > 2, "R4", "read needed several attempts", tries, 3);
        chk(rd == 32'hA1B2C3D4, "R4", "read data low-first assembly", rd, 32'hA1B2C3D4);
        drain();
        reg_acc(1'b0, 16'h0000, '0, rd);
        chk(rd == 32'h12, "R5", "pointer advanced by exactly two", rd, 32'h12);

        // R7: program memory select via pointer bit 16
        set_ptr(1'b1, 14'h020);
        ind_wr(32'hDEADBEEF, ack);
        drain();
        reg_acc(1'b0, 16'h0000, '0, rd);
        chk(rd == 32'h00010022, "R7", "pointer readback with program select", rd, 32'h00010022);
        chk(pm[8'h20] == 16'hBEEF && pm[8'h21] == 16'hDEAD, "R7", "program memory words",
            {pm[8'h21], pm[8'h20]}, 32'hDEADBEEF);

        // R8: direct mode
        reg_acc(1'b1, 16'h0001, 32'h0, rd);
        reg_acc(1'b0, 16'h0001, '0, rd);
        chk(rd == 32'h0, "R8", "mode register set to direct", rd, 32'h0);
        hacc(1'b1, 16'hC005, 32'hCAFEF00D, ack, rty, rd);
        if (ack) begin
            push_exp(1'b1, 1'b1, 14'd10, 16'hF00D);
            push_exp(1'b1, 1'b1, 14'd11, 16'hCAFE);
        end
        chk(ack, "R8", "direct write accepted", {31'b0, ack}, 1);
        drain();
        push_exp(1'b0, 1'b0, 14'd16, '0);
        push_exp(1'b0, 1'b0, 14'd17, '0);
        data_rd(16'h8008, rd, tries, first_rty);
        chk(rd == 32'hA1B2C3D4, "R8", "direct read of data dword 8", rd, 32'hA1B2C3D4);
        drain();
        push_exp(1'b0, 1'b1, 14'd10, '0);
        push_exp(1'b0, 1'b1, 14'd11, '0);
        data_rd(16'hC005, rd, tries, first_rty);
        chk(rd == 32'hCAFEF00D, "R8", "direct read of program dword 5", rd, 32'hCAFEF00D);
        drain();
        reg_acc(1'b0, 16'h0000, '0, rd);
        chk(rd == 32'h00010022, "R8", "pointer untouched in direct mode", rd, 32'h00010022);

        // R3: fill the write buffer with back-to-back writes
        reg_acc(1'b1, 16'h0001, 32'h1, rd);
        set_ptr(1'b0, 14'h040);
        for (int i = 0; i < 10; i++) begin
            ind_wr(32'h50000000 + i, ack);
            if (i < 9) chk(ack, "R3", "write accepted while buffer has room", {31'b0, ack}, 1);
            else       chk(!ack, "R3", "write retried when buffer full", {31'b0, ack}, 0);
        end
        drain();
        reg_acc(1'b0, 16'h0000, '0, rd);
        chk(rd == 32'h52, "R3", "pointer after nine accepted writes", rd, 32'h52);
        chk(dm[8'h50] == 16'h0008 && dm[8'h51] == 16'h5000, "R3", "last accepted dword stored",
            {dm[8'h51], dm[8'h50]}, 32'h50000008);
        chk(sbq.size() == 0, "R2", "all expected core words seen", sbq.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule